// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block sits beside a CPU's execute stage and turns a decoded trap request into the hardware entry sequence. Requests come in six kinds: an undefined-opcode trap, a debug-only breakpoint, a breakpoint, a conditional overflow trap, a numbered software interrupt carrying a 6-bit operand, and an acknowledged peripheral interrupt carrying its 6-bit vector number. In its idle cycle the block picks one request, decides whether it is taken and which stack applies, and then raises `busy` to stall the pipeline.

While busy it saves the pre-entry flag word and the return address on the chosen stack through a simple request/ready memory port. It then reads the handler address from a vector entry. In the final cycle it loads the new program counter, the updated flag word and the decremented stack pointer. Numbered interrupts and peripheral interrupts share one relocatable vector table, so a software interrupt can run a peripheral handler. Stack selection differs between the two sources for the upper part of the number range.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset `busy`, `mem_req`, `pc_load`, `flg_load` and `sp_load` are all 0.
- R2: When several requests are raised in the same idle cycle, exactly one is taken. The precedence from highest to lowest is undefined-opcode, debug breakpoint, breakpoint, overflow, numbered interrupt, peripheral. Mask bit positions 0..5 follow the same order.
- R3: No trap is suppressed by the interrupt-enable bit (flag bit 6). A numbered interrupt raised with that bit set still runs the full sequence.
- R4: An overflow request while the overflow bit (flag bit 2) is 0 has no effect. `busy` stays 0, there is no memory access and there is no load, and the request drops out of arbitration.
- R5: A numbered interrupt and a peripheral interrupt read their handler from `vec_base + 4*number`. The same number gives the same vector address from either source.
- R6: A numbered interrupt 0..31 clears the stack-select bit (flag bit 7) and pushes on `isp_in`. The undefined-opcode, debug breakpoint, breakpoint and overflow traps do the same.
- R7: A numbered interrupt 32..63 keeps the stack-select bit unchanged. It pushes on `usp_in` when that bit was 1 and on `isp_in` when it was 0.
- R8: A peripheral interrupt always clears the stack-select bit and uses `isp_in`, including numbers 32..48.
- R9: The flag word written to the stack is the value of `flg_in` at acceptance, before the stack-select bit is modified. It is zero-extended to 32 bits.
- R10: The memory transfers are, in this order:
  - a write of the flags to SP-4;
  - a write of `pc_ret` to SP-8;
  - a read of the vector entry.
  One cycle after the read completes, `pc_load`, `flg_load` and `sp_load` pulse together with `sp_new` = SP-8. `busy` falls in the next cycle.
- R11: Requests raised while `busy` is 1 are ignored and are not queued.
- R12: The undefined-opcode, debug breakpoint, breakpoint and overflow traps read fixed vector addresses, which are parameters (defaults 0xFFFFDC, 0xFFFFE4, 0xFFFFE0 and 0xFFFFE8).
- R13: While `mem_req` is high and `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` hold steady and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_undef | input | 1 | Undefined-opcode trap request |
| req_dbg | input | 1 | Debug-only breakpoint request |
| req_brk | input | 1 | Breakpoint request |
| req_ovf | input | 1 | Conditional overflow trap request |
| req_swi | input | 1 | Numbered software interrupt request |
| swi_num | input | 6 | Software interrupt number |
| req_irq | input | 1 | Acknowledged peripheral interrupt |
| irq_num | input | 6 | Peripheral vector number |
| flg_in | input | 16 | Current flag register |
| pc_ret | input | 24 | Return address to save |
| usp_in | input | 24 | User stack pointer |
| isp_in | input | 24 | Interrupt stack pointer |
| vec_base | input | 24 | Relocatable vector table base |
| busy | output | 1 | Pipeline stall, high during the sequence |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 24 | Read data (vector entry) |
| mem_ready | input | 1 | Transfer completes this cycle |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 24 | Handler address |
| flg_load | output | 1 | Load `flg_new` into the flag register |
| flg_new | output | 16 | Flag word after entry |
| sp_load | output | 1 | Load `sp_new` into the selected stack pointer |
| sp_sel_isp | output | 1 | 1 = the interrupt stack pointer is updated |
| sp_new | output | 24 | Stack pointer after the two pushes |

## Verification
The hardest case to reach is a request arriving while the block is mid-sequence and the memory is stalling. A stray acceptance there would show only as a second sequence after the first one completes. To get there, the stimulus adds memory wait states and pulses a higher-priority undefined-opcode request while the first trap is pushing. It then keeps watching for several cycles after the load pulse and counts loads and memory transfers. The shared-slot stack rule is reached by issuing number 40 from both sources with the stack-select bit set, and the two stack choices are compared.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int N_KIND = 6;

  // bit index of each kind doubles as its arbitration rank (0 = highest)
  typedef enum logic [2:0] {
    K_UNDEF = 3'd0,
    K_DBG   = 3'd1,
    K_BRK   = 3'd2,
    K_OVF   = 3'd3,
    K_SWI   = 3'd4,
    K_IRQ   = 3'd5
  } trap_kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PFLG = 3'd1,
    S_PPC  = 3'd2,
    S_VEC  = 3'd3,
    S_LOAD = 3'd4
  } seq_st_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int O_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KIND-1:0] req,
  input  logic [FLAG_W-1:0] flg,
  output logic [N_KIND-1:0] grant,
  output trap_kind_e        kind,
  output logic              any
);
  logic [N_KIND-1:0] eligible;
  logic              found;

  // an overflow request only counts when the overflow bit is set
  always_comb begin
    eligible        = req;
    eligible[K_OVF] = req[K_OVF] & flg[O_BIT];
  end

  always_comb begin
    grant = '0;
    kind  = K_UNDEF;
    found = 1'b0;
    for (int i = 0; i < N_KIND; i++) begin
      if (eligible[i] && !found) begin
        grant[i] = 1'b1;
        kind     = trap_kind_e'(3'(i));
        found    = 1'b1;
      end
    end
  end

  assign any = found;

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_ovf_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant[K_OVF] |-> flg[O_BIT]);
endmodule

// File: rtl/trap_ctx.sv
module trap_ctx
  import trap_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              FLAG_W     = 16,
  parameter int              NUM_W      = 6,
  parameter int              U_BIT      = 7,
  parameter int              VEC_STRIDE = 4,
  parameter logic [ADDR_W-1:0] VEC_UNDEF = 24'hFFFFDC,
  parameter logic [ADDR_W-1:0] VEC_DBG   = 24'hFFFFE4,
  parameter logic [ADDR_W-1:0] VEC_BRK   = 24'hFFFFE0,
  parameter logic [ADDR_W-1:0] VEC_OVF   = 24'hFFFFE8
) (
  input  trap_kind_e        kind,
  input  logic [NUM_W-1:0]  swi_num,
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [FLAG_W-1:0] flg,
  input  logic [ADDR_W-1:0] usp,
  input  logic [ADDR_W-1:0] isp,
  input  logic [ADDR_W-1:0] vec_base,
  output logic [FLAG_W-1:0] flg_next,
  output logic              use_isp,
  output logic [ADDR_W-1:0] sp_base,
  output logic [ADDR_W-1:0] vaddr
);
  localparam int unsigned KEEP_FROM = 1 << (NUM_W - 1);

  function automatic logic [ADDR_W-1:0] vec_entry(input logic [ADDR_W-1:0] base,
                                                  input logic [NUM_W-1:0]  num);
    return base + ADDR_W'(num) * ADDR_W'(VEC_STRIDE);
  endfunction

  logic keep_u;

  // only upper-half software numbers leave the stack-select bit alone
  assign keep_u = (kind == K_SWI) && (32'(swi_num) >= KEEP_FROM);

  always_comb begin
    flg_next = flg;
    if (!keep_u) flg_next[U_BIT] = 1'b0;
  end

  // stack choice follows the already-updated flag word
  assign use_isp = !flg_next[U_BIT];
  assign sp_base = use_isp ? isp : usp;

  always_comb begin
    unique case (kind)
      K_UNDEF: vaddr = VEC_UNDEF;
      K_DBG:   vaddr = VEC_DBG;
      K_BRK:   vaddr = VEC_BRK;
      K_OVF:   vaddr = VEC_OVF;
      K_SWI:   vaddr = vec_entry(vec_base, swi_num);
      default: vaddr = vec_entry(vec_base, irq_num);
    endcase
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              DATA_W     = 32,
  parameter int              FLAG_W     = 16,
  parameter int              NUM_W      = 6,
  parameter int              U_BIT      = 7,
  parameter int              O_BIT      = 2,
  parameter int              STEP       = 4,
  parameter int              VEC_STRIDE = 4,
  parameter logic [ADDR_W-1:0] VEC_UNDEF = 24'hFFFFDC,
  parameter logic [ADDR_W-1:0] VEC_DBG   = 24'hFFFFE4,
  parameter logic [ADDR_W-1:0] VEC_BRK   = 24'hFFFFE0,
  parameter logic [ADDR_W-1:0] VEC_OVF   = 24'hFFFFE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_undef,
  input  logic              req_dbg,
  input  logic              req_brk,
  input  logic              req_ovf,
  input  logic              req_swi,
  input  logic [NUM_W-1:0]  swi_num,
  input  logic              req_irq,
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [FLAG_W-1:0] flg_in,
  input  logic [ADDR_W-1:0] pc_ret,
  input  logic [ADDR_W-1:0] usp_in,
  input  logic [ADDR_W-1:0] isp_in,
  input  logic [ADDR_W-1:0] vec_base,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new,
  output logic              flg_load,
  output logic [FLAG_W-1:0] flg_new,
  output logic              sp_load,
  output logic              sp_sel_isp,
  output logic [ADDR_W-1:0] sp_new
);
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] sp,
                                                  input int unsigned       n);
    return sp - ADDR_W'(n * STEP);
  endfunction

  logic [N_KIND-1:0] req_vec;
  logic [N_KIND-1:0] grant;
  trap_kind_e        kind;
  logic              any_req;
  logic [FLAG_W-1:0] flg_next;
  logic              use_isp;
  logic [ADDR_W-1:0] sp_base;
  logic [ADDR_W-1:0] vaddr;
  logic              accept;
  logic              xfer_done;

  seq_st_e           st;
  trap_kind_e        kind_q;
  logic [FLAG_W-1:0] saved_q;
  logic [FLAG_W-1:0] newflg_q;
  logic              isp_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [ADDR_W-1:0] vec_q;

  assign req_vec = {req_irq, req_swi, req_ovf, req_brk, req_dbg, req_undef};

  trap_arbiter #(.FLAG_W(FLAG_W), .O_BIT(O_BIT)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_vec),
    .flg   (flg_in),
    .grant (grant),
    .kind  (kind),
    .any   (any_req)
  );

  trap_ctx #(
    .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .NUM_W(NUM_W), .U_BIT(U_BIT),
    .VEC_STRIDE(VEC_STRIDE), .VEC_UNDEF(VEC_UNDEF), .VEC_DBG(VEC_DBG),
    .VEC_BRK(VEC_BRK), .VEC_OVF(VEC_OVF)
  ) u_ctx (
    .kind     (kind),
    .swi_num  (swi_num),
    .irq_num  (irq_num),
    .flg      (flg_in),
    .usp      (usp_in),
    .isp      (isp_in),
    .vec_base (vec_base),
    .flg_next (flg_next),
    .use_isp  (use_isp),
    .sp_base  (sp_base),
    .vaddr    (vaddr)
  );

  assign busy      = (st != S_IDLE);
  assign accept    = (st == S_IDLE) && any_req;
  assign xfer_done = mem_req && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  if (accept)    st <= S_PFLG;
        S_PFLG:  if (mem_ready) st <= S_PPC;
        S_PPC:   if (mem_ready) st <= S_VEC;
        S_VEC:   if (mem_ready) st <= S_LOAD;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= K_UNDEF;
      saved_q  <= '0;
      newflg_q <= '0;
      isp_q    <= 1'b1;
      sp_q     <= '0;
      pc_q     <= '0;
      vaddr_q  <= '0;
      vec_q    <= '0;
    end else begin
      if (accept) begin
        kind_q   <= kind;
        saved_q  <= flg_in;
        newflg_q <= flg_next;
        isp_q    <= use_isp;
        sp_q     <= sp_base;
        pc_q     <= pc_ret;
        vaddr_q  <= vaddr;
      end
      if (st == S_VEC && mem_ready) vec_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_PFLG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_addr(sp_q, 1);
        mem_wdata = DATA_W'(saved_q);
      end
      S_PPC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_addr(sp_q, 2);
        mem_wdata = DATA_W'(pc_q);
      end
      S_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vaddr_q;
      end
      default: ;
    endcase
  end

  assign pc_load    = (st == S_LOAD);
  assign flg_load   = (st == S_LOAD);
  assign sp_load    = (st == S_LOAD);
  assign pc_new     = vec_q;
  assign flg_new    = newflg_q;
  assign sp_sel_isp = isp_q;
  assign sp_new     = slot_addr(sp_q, 2);

  // R13: stalled transfer keeps its request stable
  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata)));

  assert_accept_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && mem_req && mem_we));

  assert_load_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (!busy && !pc_load));

  assert_read_before_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !mem_we) |=> pc_load);

  // R6 / R7: stack updated is the one the new flag word selects
  assert_stack_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (sp_sel_isp == !flg_new[U_BIT]));

  assert_irq_isp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && kind_q == K_IRQ) |-> (sp_sel_isp && !flg_new[U_BIT]));
endmodule

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam logic [23:0] USP  = 24'h004000;
  localparam logic [23:0] ISP  = 24'h008000;
  localparam logic [23:0] VB   = 24'h0F0000;
  localparam logic [23:0] RPC  = 24'h012346;
  localparam logic [23:0] XORK = 24'h5A0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_undef = 0, req_dbg = 0, req_brk = 0, req_ovf = 0, req_swi = 0, req_irq = 0;
  logic [5:0]  swi_num = 0, irq_num = 0;
  logic [15:0] flg_in = 0;
  logic        busy, mem_req, mem_we, mem_ready;
  logic [23:0] mem_addr, mem_rdata, pc_new, sp_new;
  logic [31:0] mem_wdata;
  logic        pc_load, flg_load, sp_load, sp_sel_isp;
  logic [15:0] flg_new;

  int checks = 0;
  int errors = 0;
  int wait_n = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .req_undef(req_undef), .req_dbg(req_dbg), .req_brk(req_brk), .req_ovf(req_ovf),
    .req_swi(req_swi), .swi_num(swi_num), .req_irq(req_irq), .irq_num(irq_num),
    .flg_in(flg_in), .pc_ret(RPC), .usp_in(USP), .isp_in(ISP), .vec_base(VB),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_load(pc_load), .pc_new(pc_new), .flg_load(flg_load), .flg_new(flg_new),
    .sp_load(sp_load), .sp_sel_isp(sp_sel_isp), .sp_new(sp_new)
  );

  // memory model with programmable wait states
  int wcnt = 0;
  assign mem_ready = mem_req && (wcnt >= wait_n);
  assign mem_rdata = mem_addr ^ XORK;

  logic [23:0] lg_addr [64];
  logic [31:0] lg_wd   [64];
  logic        lg_we   [64];
  int          lg_n = 0;
  int          ld_cnt = 0, busy_cnt = 0;
  logic [23:0] ld_pc, ld_sp;
  logic [15:0] ld_flg;
  logic        ld_isp, ld_all;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy) busy_cnt <= busy_cnt + 1;
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready) begin
      lg_addr[lg_n % 64] <= mem_addr;
      lg_wd[lg_n % 64]   <= mem_wdata;
      lg_we[lg_n % 64]   <= mem_we;
      lg_n <= lg_n + 1;
    end
    if (pc_load) begin
      ld_cnt <= ld_cnt + 1;
      ld_pc  <= pc_new;
      ld_sp  <= sp_new;
      ld_flg <= flg_new;
      ld_isp <= sp_sel_isp;
      ld_all <= flg_load && sp_load;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] mask, input logic [5:0] num, input logic [15:0] f);
    @(negedge clk);
    flg_in = f; swi_num = num; irq_num = num;
    {req_irq, req_swi, req_ovf, req_brk, req_dbg, req_undef} = mask;
    @(negedge clk);
    {req_irq, req_swi, req_ovf, req_brk, req_dbg, req_undef} = 6'b0;
  endtask

  // mask bits: 0 undef, 1 dbg, 2 brk, 3 ovf, 4 swi, 5 irq
  task automatic do_trap(input logic [5:0] mask, input logic [5:0] num, input logic [15:0] f,
                         input logic [23:0] evec, input logic [15:0] eflg, input bit eisp,
                         input bit inject, input string tag);
    int b_lg = lg_n;
    int b_ld = ld_cnt;
    logic [23:0] sp = eisp ? ISP : USP;
    drive(mask, num, f);
    if (inject) begin
      req_undef = 1'b1;
      @(negedge clk);
      req_undef = 1'b0;
    end
    for (int i = 0; i < 80 && ld_cnt == b_ld; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(ld_cnt == b_ld + 1, {tag, " one load (R10 R11)"}, ld_cnt - b_ld, 1);
    chk(lg_n == b_lg + 3, {tag, " three transfers (R10 R11)"}, lg_n - b_lg, 3);
    chk(lg_we[b_lg % 64] && lg_addr[b_lg % 64] == sp - 24'd4, {tag, " flag push addr R10"},
        lg_addr[b_lg % 64], sp - 24'd4);
    chk(lg_wd[b_lg % 64] == {16'h0, f}, {tag, " saved flags pre-update R9"},
        lg_wd[b_lg % 64], {16'h0, f});
    chk(lg_we[(b_lg + 1) % 64] && lg_addr[(b_lg + 1) % 64] == sp - 24'd8
        && lg_wd[(b_lg + 1) % 64] == {8'h0, RPC}, {tag, " pc push R10"},
        lg_addr[(b_lg + 1) % 64], sp - 24'd8);
    chk(!lg_we[(b_lg + 2) % 64] && lg_addr[(b_lg + 2) % 64] == evec, {tag, " vector addr R5 R12"},
        lg_addr[(b_lg + 2) % 64], evec);
    chk(ld_pc == (evec ^ XORK), {tag, " new pc R10"}, ld_pc, evec ^ XORK);
    chk(ld_flg == eflg, {tag, " new flags R6 R7 R8"}, ld_flg, eflg);
    chk(ld_isp == eisp && ld_sp == sp - 24'd8 && ld_all, {tag, " stack select R6 R7 R8"},
        {7'h0, ld_isp, ld_sp}, {7'h0, eisp, sp - 24'd8});
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !pc_load && !flg_load && !sp_load, "R1 reset outputs",
        {27'h0, busy, mem_req, pc_load, flg_load, sp_load}, 0);
  endtask

  task automatic t_swi_low;
    // R3: interrupt-enable bit 6 set, stack-select bit 7 set
    do_trap(6'b010000, 6'd5, 16'h00C0, VB + 24'd20, 16'h0040, 1'b1, 1'b0, "R3 R6 swi5");
  endtask

  task automatic t_swi_high;
    do_trap(6'b010000, 6'd40, 16'h0080, VB + 24'd160, 16'h0080, 1'b0, 1'b0, "R7 swi40 U=1");
    do_trap(6'b010000, 6'd63, 16'h0001, VB + 24'd252, 16'h0001, 1'b1, 1'b0, "R7 swi63 U=0");
    do_trap(6'b010000, 6'd32, 16'h0080, VB + 24'd128, 16'h0080, 1'b0, 1'b0, "R7 swi32 edge");
    do_trap(6'b010000, 6'd31, 16'h0080, VB + 24'd124, 16'h0000, 1'b1, 1'b0, "R6 swi31 edge");
  endtask

  task automatic t_irq_shared;
    do_trap(6'b100000, 6'd40, 16'h0080, VB + 24'd160, 16'h0000, 1'b1, 1'b0, "R8 R5 irq40");
    do_trap(6'b100000, 6'd48, 16'h0084, VB + 24'd192, 16'h0004, 1'b1, 1'b0, "R8 irq48");
  endtask

  task automatic t_ovf_clear;
    int b_lg = lg_n;
    int b_ld = ld_cnt;
    int b_bz = busy_cnt;
    drive(6'b001000, 6'd0, 16'h0080);
    repeat (10) @(negedge clk);
    chk(busy_cnt == b_bz && lg_n == b_lg && ld_cnt == b_ld, "R4 overflow clear no-op",
        busy_cnt - b_bz + lg_n - b_lg, 0);
  endtask

  task automatic t_fixed;
    do_trap(6'b000001, 6'd0, 16'h0080, 24'hFFFFDC, 16'h0000, 1'b1, 1'b0, "R12 undef");
    do_trap(6'b000010, 6'd0, 16'h0080, 24'hFFFFE4, 16'h0000, 1'b1, 1'b0, "R12 dbg");
    do_trap(6'b000100, 6'd0, 16'h0080, 24'hFFFFE0, 16'h0000, 1'b1, 1'b0, "R12 brk");
    do_trap(6'b001000, 6'd0, 16'h0084, 24'hFFFFE8, 16'h0004, 1'b1, 1'b0, "R12 ovf set");
  endtask

  task automatic t_priority;
    do_trap(6'b111111, 6'd9, 16'h0084, 24'hFFFFDC, 16'h0004, 1'b1, 1'b0, "R2 all");
    do_trap(6'b111110, 6'd9, 16'h0084, 24'hFFFFE4, 16'h0004, 1'b1, 1'b0, "R2 dbg wins");
    do_trap(6'b111100, 6'd9, 16'h0084, 24'hFFFFE0, 16'h0004, 1'b1, 1'b0, "R2 brk wins");
    do_trap(6'b111000, 6'd9, 16'h0084, 24'hFFFFE8, 16'h0004, 1'b1, 1'b0, "R2 ovf wins");
    do_trap(6'b111000, 6'd40, 16'h0080, VB + 24'd160, 16'h0080, 1'b0, 1'b0, "R2 R4 ovf clear drops");
    do_trap(6'b110000, 6'd40, 16'h0080, VB + 24'd160, 16'h0080, 1'b0, 1'b0, "R2 swi over irq");
  endtask

  task automatic t_busy_stall;
    wait_n = 3;
    do_trap(6'b010000, 6'd10, 16'h0080, VB + 24'd40, 16'h0000, 1'b1, 1'b1, "R11 R13 inject stalled");
    wait_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_swi_low();
    t_swi_high();
    t_irq_shared();
    t_ovf_clear();
    t_fixed();
    t_priority();
    t_busy_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule